// File: doc/BRIEF.md
# VF Display Dimming and Multiplex Timer

This block produces the multiplex timing and the brightness pulse for a two-line dot-matrix vacuum-fluorescent display. It runs from a 4 MHz reference clock, one period per clock. Each display cycle is made of fixed slots of 1024 reference periods, one slot for each pair of digits. In every slot the `duty` output is high for a programmed number of periods. That number sets the display brightness.

A one-cycle slot strobe and the current pair index tell the grid and segment logic when to advance. A cycle-done pulse marks the final period of the cycle. The brightness value and the pair count come from host registers through plain level inputs. Both are captured only on the first period of a display cycle, so a host write never bends a pulse that is already running.

The block has no data stream, so there is no valid/ready interface and no back-pressure. All pins are plain control or status pins.

Top module: `vfd_duty_timer`

## Requirements
- R1: While `rst_n` is low, `duty`, `slot_stb` and `cycle_done` are 0 and `pair_idx` is 0.
- R2: A slot lasts exactly 1024 reference periods. `slot_stb` is high for one period, on the first period of every slot.
- R3: Within a slot, `duty` is high on period offsets 0 through N-1 and low on the rest, where N is the captured on-count. An on-count of 0 keeps `duty` low for the whole slot.
- R4: The on-count is `dim_level` (an unsigned 10-bit value) limited to 976. Any value above 976 behaves as 976.
- R5: A cycle has P slots, where P is `pair_count` (unsigned, 5 bits) limited to the range 1 to 16. The value 0 acts as 1 and any value above 16 acts as 16.
- R6: `pair_idx` is 0 in the first slot of a cycle and rises by one at each slot boundary, up to P-1. It then wraps to 0 for the next cycle.
- R7: `cycle_done` is high for exactly one period: the last period (offset 1023) of slot P-1.
- R8: `dim_level` and `pair_count` are captured on the first period of a cycle (slot 0, offset 0). Changes at any other time take effect only at the start of the next cycle.
- R9: The same on-count applies to every slot of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dim_level | input | 10 | Requested on-count per slot |
| pair_count | input | 5 | Requested number of digit pairs per cycle |
| duty | output | 1 | Dimming pulse |
| slot_stb | output | 1 | First-period strobe of each slot |
| pair_idx | output | 4 | Index of the current digit pair |
| cycle_done | output | 1 | Last period of the display cycle |

## Verification
The assertions assume that `dim_level` and `pair_count` are synchronous to `clk` and settle before each rising edge. They accept any value on either input, including 0, the values above the limits, and changes in mid-cycle. The stimulus changes the inputs just after a rising edge and covers the whole input range. Some changes are held across whole cycles and others fall in the middle of a slot. A few directed settings hit the limit values: an on-count of 0, 976 and 1023, and a pair count of 0, 1, 16 and 31.

// File: rtl/vfd_tim_pkg.sv
package vfd_tim_pkg;
  // Limit a requested on-count to the largest allowed value.
  function automatic int unsigned limit_on(int unsigned req, int unsigned on_max);
    return (req > on_max) ? on_max : req;
  endfunction

  // Turn a requested pair count into the index of the final slot.
  function automatic int unsigned final_slot(int unsigned req, int unsigned max_pairs);
    if (req == 0) return 0;
    if (req > max_pairs) return max_pairs - 1;
    return req - 1;
  endfunction
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
  parameter int SLOT_LEN = 1024,
  localparam int SLOT_W = $clog2(SLOT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] offset,
  output logic              slot_first,
  output logic              slot_last
);
  assign slot_first = (offset == '0);
  assign slot_last  = (offset == SLOT_W'(SLOT_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         offset <= '0;
    else if (slot_last) offset <= '0;
    else                offset <= offset + 1'b1;
  end
endmodule

// File: rtl/vfd_pair_seq.sv
module vfd_pair_seq #(
  parameter int MAX_PAIRS = 16,
  localparam int IDX_W = $clog2(MAX_PAIRS),
  localparam int PC_W  = $clog2(MAX_PAIRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_last,
  input  logic             cyc_start,
  input  logic [PC_W-1:0]  pair_req,
  output logic [IDX_W-1:0] idx,
  output logic             on_final
);
  import vfd_tim_pkg::*;

  logic [IDX_W-1:0] final_q;
  logic [IDX_W-1:0] final_live;
  logic [IDX_W-1:0] final_eff;

  assign final_live = IDX_W'(final_slot(int'(pair_req), MAX_PAIRS));
  assign final_eff  = cyc_start ? final_live : final_q;
  assign on_final   = (idx == final_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_q <= '0;
      idx     <= '0;
    end else begin
      if (cyc_start) final_q <= final_live;
      if (slot_last) idx <= on_final ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/vfd_duty_gen.sv
module vfd_duty_gen #(
  parameter int SLOT_LEN = 1024,
  parameter int ON_MAX   = 976,
  parameter int DIM_W    = 10,
  localparam int SLOT_W = $clog2(SLOT_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic [DIM_W-1:0]  dim_req,
  input  logic [SLOT_W-1:0] offset,
  output logic              pulse
);
  import vfd_tim_pkg::*;

  logic [DIM_W-1:0] on_q;
  logic [DIM_W-1:0] on_live;
  logic [DIM_W-1:0] on_eff;

  assign on_live = DIM_W'(limit_on(int'(dim_req), ON_MAX));
  assign on_eff  = cyc_start ? on_live : on_q;
  assign pulse   = 32'(offset) < 32'(on_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         on_q <= '0;
    else if (cyc_start) on_q <= on_live;
  end
endmodule

// File: rtl/vfd_duty_timer.sv
module vfd_duty_timer #(
  parameter int SLOT_LEN  = 1024,
  parameter int ON_MAX    = 976,
  parameter int MAX_PAIRS = 16,
  parameter int DIM_W     = 10,
  localparam int SLOT_W = $clog2(SLOT_LEN),
  localparam int IDX_W  = $clog2(MAX_PAIRS),
  localparam int PC_W   = $clog2(MAX_PAIRS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] dim_level,
  input  logic [PC_W-1:0]  pair_count,
  output logic             duty,
  output logic             slot_stb,
  output logic [IDX_W-1:0] pair_idx,
  output logic             cycle_done
);
  logic [SLOT_W-1:0] offset;
  logic              slot_first;
  logic              slot_last;
  logic              cyc_start;
  logic              on_final;
  logic              pulse;
  logic [IDX_W-1:0]  idx;

  vfd_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_slot (
    .clk(clk), .rst_n(rst_n), .offset(offset),
    .slot_first(slot_first), .slot_last(slot_last)
  );

  vfd_pair_seq #(.MAX_PAIRS(MAX_PAIRS)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_last(slot_last), .cyc_start(cyc_start),
    .pair_req(pair_count), .idx(idx), .on_final(on_final)
  );

  assign cyc_start = slot_first && (idx == '0);

  vfd_duty_gen #(.SLOT_LEN(SLOT_LEN), .ON_MAX(ON_MAX), .DIM_W(DIM_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .dim_req(dim_level),
    .offset(offset), .pulse(pulse)
  );

  assign duty       = rst_n && pulse;
  assign slot_stb   = rst_n && slot_first;
  assign pair_idx   = idx;
  assign cycle_done = rst_n && slot_last && on_final;
endmodule

// File: rtl/vfd_duty_timer_chk.sv
module vfd_duty_timer_chk #(
  parameter int SLOT_LEN  = 1024,
  parameter int ON_MAX    = 976,
  parameter int IDX_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             duty,
  input logic             slot_stb,
  input logic [IDX_W-1:0] pair_idx,
  input logic             cycle_done
);
  int unsigned hi_run;

  // Count the high periods of duty since the latest slot strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_run <= 0;
    else if (slot_stb) hi_run <= duty ? 1 : 0;
    else               hi_run <= hi_run + (duty ? 1 : 0);
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb |=> !slot_stb); // R2
  AST_DUTY_RISE_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(duty) |-> slot_stb); // R3
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= ON_MAX); // R4
  AST_DONE_LOW_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> !duty); // R4
  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |-> $stable(pair_idx)); // R6
  AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> (slot_stb && pair_idx == '0)); // R7
endmodule

bind vfd_duty_timer vfd_duty_timer_chk #(
  .SLOT_LEN(SLOT_LEN), .ON_MAX(ON_MAX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .duty(duty), .slot_stb(slot_stb),
  .pair_idx(pair_idx), .cycle_done(cycle_done)
);

// File: tb/test_vfd_duty_timer.sv
module test_vfd_duty_timer;
  localparam int SLOT = 1024;
  localparam int ONMX = 976;
  localparam int MAXP = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] dim_level = 0;
  logic [4:0] pair_count = 0;
  logic       duty, slot_stb, cycle_done;
  logic [3:0] pair_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vfd_duty_timer i_vfd_duty_timer (
    .clk(clk), .rst_n(rst_n), .dim_level(dim_level), .pair_count(pair_count),
    .duty(duty), .slot_stb(slot_stb), .pair_idx(pair_idx), .cycle_done(cycle_done)
  );

  function automatic int exp_on(int v);
    return (v > ONMX) ? ONMX : v;
  endfunction

  function automatic int exp_final(int pc);
    if (pc == 0) return 0;
    if (pc > MAXP) return MAXP - 1;
    return pc - 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Reference position and captured settings, following the requirements
  int m_off = 0, m_idx = 0, m_on = 0, m_fin = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off <= 0; m_idx <= 0; m_on <= 0; m_fin <= 0;
    end else begin
      automatic bit st = (m_off == 0 && m_idx == 0);
      automatic int fin = st ? exp_final(pair_count) : m_fin;
      if (st) begin
        m_on  <= exp_on(dim_level);
        m_fin <= exp_final(pair_count);
      end
      if (m_off == SLOT - 1) begin
        m_off <= 0;
        m_idx <= (m_idx == fin) ? 0 : m_idx + 1;
      end else m_off <= m_off + 1;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        check(duty == 0 && slot_stb == 0 && cycle_done == 0 && pair_idx == 0,
              "R1 reset outputs", {duty, slot_stb, cycle_done, pair_idx}, 0);
      end else begin
        automatic bit st = (m_off == 0 && m_idx == 0);
        automatic int on = st ? exp_on(dim_level) : m_on;
        automatic int fin = st ? exp_final(pair_count) : m_fin;
        check(duty == (m_off < on), "R3 R4 R8 R9 duty", duty, int'(m_off < on));
        check(slot_stb == (m_off == 0), "R2 slot strobe", slot_stb, int'(m_off == 0));
        check(int'(pair_idx) == m_idx, "R6 pair index", pair_idx, m_idx);
        check(cycle_done == (m_off == SLOT - 1 && m_idx == fin), "R5 R7 cycle done",
              cycle_done, int'(m_off == SLOT - 1 && m_idx == fin));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_in(int d, int p);
    dim_level  = 10'(d);
    pair_count = 5'(p);
  endtask

  initial begin
    void'($urandom(32'd20517));
    set_in(300, 2);
    step(5);
    rst_n = 1;
    // Directed corner cases
    set_in(0, 2);    step(2 * SLOT);            // R3 zero on-count
    set_in(976, 1);  step(2 * SLOT);            // R4 at the limit, R5 single pair
    set_in(1023, 0); step(2 * SLOT);            // R4 above limit, R5 zero acts as one
    set_in(500, 3);  step(SLOT + 17);           // R8 mid-cycle change
    set_in(10, 5);   step(3 * SLOT);
    set_in(700, 31); step(16 * SLOT + 40);      // R5 above 16, R9 all slots
    set_in(1, 16);   step(16 * SLOT);
    // Random phase
    for (int k = 0; k < 40; k++) begin
      automatic int d = ($urandom % 4 == 0) ? 960 + ($urandom % 64) : $urandom % 1024;
      set_in(d, $urandom % 32);
      step(1 + $urandom % 2500);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule